// File: doc/BRIEF.md
# Per-Page Endian Coherency Selector

This block sits between a processor load/store port and a 32-bit memory bus. For each access it picks one of two ways of reconciling big- and little-endian views of memory. The first way, lane swizzling, rewrites the low address bits of byte and halfword accesses and leaves the data alone. The second way, word reversal, leaves the address alone and reverses the four bytes of the data word. The choice depends on two inputs. One is a global enable held in a configuration register. The other is a page attribute bit that arrives with every request and is constant across each 1-Mbyte region.

Requests pass through to the bus in the same cycle. Read data returns later, in issue order. The method chosen for a read is remembered in a small in-order queue, so the returning data is converted the same way the request was, even if the global enable changes while the read is outstanding.

Top module: `endian_sel`

## Requirements
- R1: After reset the global enable is 0, so the first accesses use lane swizzling whatever the page attribute is.
- R2: While the global enable is 0, every access uses lane swizzling, for page attribute 0 and for page attribute 1.
- R3: While the global enable is 1, a page attribute of 1 selects word reversal and a page attribute of 0 selects lane swizzling.
- R4: Lane swizzling works as follows for size codes 0 (byte), 1 (halfword) and 2 (word). Address bits [1:0] are XORed with 3 for bytes and with 2 for halfwords, and word addresses pass unchanged. Write data and read data pass unchanged.
- R5: Word reversal passes the address unchanged and maps data byte k to byte 3-k, for write data and for read data alike.
- R6: The global enable is bit 8 of the configuration write data. Writing any value to the other 31 bits does not change the enable.
- R7: A configuration write takes effect from the next clock cycle. A request in the same cycle as the write is converted with the old enable.
- R8: A read uses the method chosen when it was issued, and its returning data is converted with that method even if the enable changed in between.
- R9: Up to DEPTH reads (default 4) may be outstanding. Their data returns in issue order, and each is converted with its own method. A read may be issued in the same cycle as an earlier read's data returns.
- R10: Address bits [31:2], the size code, the write flag and the valid flag pass to the bus unchanged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data; bit 8 is the global enable |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | 32 | Request byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Store data |
| req_page_attr | input | 1 | Page attribute of the addressed 1-Mbyte page |
| bus_valid | output | 1 | Request to memory bus |
| bus_write | output | 1 | Store flag to memory bus |
| bus_addr | output | 32 | Converted address |
| bus_size | output | 2 | Access size to memory bus |
| bus_wdata | output | 32 | Converted store data |
| bus_rvalid | input | 1 | Read data returning from bus |
| bus_rdata | input | 32 | Raw read data from bus |
| rsp_valid | output | 1 | Read data to processor |
| rsp_rdata | output | 32 | Converted read data |

## Verification
Two events can land in the same cycle. A configuration write can coincide with a request, and a read can be issued while an older read's data is returning. The bench drives a write that sets the enable together with a word-reversal store, and expects the store to be swizzled with the old enable, then reversed one cycle later. It also changes the enable while a read is outstanding and issues a new read in the very cycle the older data returns. Each returning word is compared against a reference conversion using the method that was in force when that read was issued.

// File: rtl/endian_sel.sv
`timescale 1ns/1ps
module endian_sel #(
  parameter int AW     = 32,
  parameter int DEPTH  = 4,
  parameter int EN_BIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_wdata,
  input  logic          req_page_attr,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [31:0]   bus_wdata,
  input  logic          bus_rvalid,
  input  logic [31:0]   bus_rdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [31:0] rev_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  logic swap_en_q;
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[31:EN_BIT+1], cfg_wdata[EN_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)      swap_en_q <= 1'b0;
    else if (cfg_we) swap_en_q <= cfg_wdata[EN_BIT];
  end

  logic       word_mode;
  logic [1:0] lane_flip;
  assign word_mode = swap_en_q & req_page_attr;
  assign lane_flip = (req_size == 2'd0) ? 2'b11 :
                     (req_size == 2'd1) ? 2'b10 : 2'b00;

  assign bus_valid = req_valid;
  assign bus_write = req_write;
  assign bus_size  = req_size;
  assign bus_addr  = word_mode ? req_addr : {req_addr[AW-1:2], req_addr[1:0] ^ lane_flip};
  assign bus_wdata = word_mode ? rev_bytes(req_wdata) : req_wdata;

  logic [DEPTH-1:0] mode_q;
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             push, pop;

  assign push = req_valid & ~req_write;
  assign pop  = bus_rvalid;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      mode_q <= '0;
    end else begin
      if (push) begin
        mode_q[wr_ptr] <= word_mode;
        wr_ptr         <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign rsp_valid = bus_rvalid;
  assign rsp_rdata = mode_q[rd_ptr] ? rev_bytes(bus_rdata) : bus_rdata;

  assert_reset_off_R1: assert property (@(posedge clk) !rst_n |=> !swap_en_q);
  assert_cfg_next_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> swap_en_q == $past(cfg_wdata[EN_BIT]));
  assert_hold_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(swap_en_q));
  assert_upper_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> bus_addr[AW-1:2] == req_addr[AW-1:2]);
  assert_off_passes_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !swap_en_q) |-> bus_wdata == req_wdata);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CW'(DEPTH) || pop));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> count != '0);
endmodule

// File: tb/endian_sel_test.sv
`timescale 1ns/1ps
module endian_sel_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_we, req_valid, req_write, req_page_attr, bus_rvalid;
  logic [31:0] cfg_wdata, req_addr, req_wdata, bus_rdata;
  logic [1:0]  req_size;
  logic bus_valid, bus_write, rsp_valid;
  logic [31:0] bus_addr, bus_wdata, rsp_rdata;
  logic [1:0]  bus_size;
  int total = 0, bad = 0;

  endian_sel uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .req_page_attr(req_page_attr),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  function automatic logic [31:0] exp_addr(bit en, bit attr, logic [1:0] sz, logic [31:0] a);
    if (en && attr) return a;
    case (sz)
      2'd0:    return a ^ 32'd3;
      2'd1:    return a ^ 32'd2;
      default: return a;
    endcase
  endfunction

  function automatic logic [31:0] exp_data(bit en, bit attr, logic [31:0] d);
    return (en && attr) ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0; req_addr = 0; req_size = 0;
    req_wdata = 0; req_page_attr = 0; cfg_we = 0; cfg_wdata = 0;
    bus_rvalid = 0; bus_rdata = 0;
  endtask

  task automatic set_cfg(logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic access(string tag, bit en, bit attr, logic [1:0] sz,
                        logic [31:0] a, logic [31:0] d, bit wr);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz;
    req_wdata = d; req_page_attr = attr;
    #1;
    check({tag, " addr"}, bus_addr, exp_addr(en, attr, sz, a));
    check({tag, " R10 ctl"}, {28'd0, bus_valid, bus_write, bus_size}, {28'd0, 1'b1, wr, sz});
    if (wr) check({tag, " wdata"}, bus_wdata, exp_data(en, attr, d));
    else begin
      @(negedge clk);
      req_valid = 0; bus_rvalid = 1; bus_rdata = ~d;
      #1;
      check({tag, " rdata"}, rsp_rdata, exp_data(en, attr, ~d));
      check({tag, " rvalid"}, {31'd0, rsp_valid}, 32'd1);
      @(negedge clk); bus_rvalid = 0;
    end
    req_valid = 0;
  endtask

  task automatic t_reset();
    access("R1 after reset", 0, 1, 2'd0, 32'h0000_1000, 32'h1122_3344, 1);
  endtask

  task automatic t_sweep();
    for (int en = 0; en < 2; en++) begin
      set_cfg(en[0] ? 32'h100 : 32'h0);
      for (int at = 0; at < 2; at++)
        for (int sz = 0; sz < 3; sz++)
          for (int wr = 0; wr < 2; wr++)
            access(en ? (at ? "R3 R5" : "R3 R4") : "R2 R4", en[0], at[0], sz[1:0],
                   32'h0ab0_0000 + 32'(sz * 16 + at * 4 + 1), 32'hA0B1_C2D3 + 32'(sz), wr[0]);
    end
  endtask

  task automatic t_cfg_bits();
    set_cfg(32'hFFFF_FEFF);
    access("R6 other bits", 0, 1, 2'd0, 32'h0010_0004, 32'h5566_7788, 1);
    set_cfg(32'h0000_0100);
    access("R6 bit8", 1, 1, 2'd1, 32'h0010_0006, 32'h5566_7788, 1);
  endtask

  task automatic t_same_cycle();
    set_cfg(32'h0);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = 32'h100;
    req_valid = 1; req_write = 1; req_size = 0; req_addr = 32'h100;
    req_wdata = 32'h1122_3344; req_page_attr = 1;
    #1;
    check("R7 old enable addr", bus_addr, 32'h103);
    check("R7 old enable data", bus_wdata, 32'h1122_3344);
    @(negedge clk); cfg_we = 0;
    #1;
    check("R7 new enable addr", bus_addr, 32'h100);
    check("R7 new enable data", bus_wdata, 32'h4433_2211);
    req_valid = 0;
  endtask

  task automatic t_latched();
    set_cfg(32'h100);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_size = 2; req_addr = 32'h200; req_page_attr = 1;
    @(negedge clk); req_valid = 0; cfg_we = 1; cfg_wdata = 0;
    @(negedge clk); cfg_we = 0;
    bus_rvalid = 1; bus_rdata = 32'hA1B2_C3D4;
    req_valid = 1; req_size = 0; req_addr = 32'h300; req_page_attr = 1;
    #1;
    check("R8 latched rdata", rsp_rdata, 32'hD4C3_B2A1);
    check("R9 issue on return addr", bus_addr, 32'h303);
    @(negedge clk); req_valid = 0; bus_rdata = 32'h0102_0304;
    #1;
    check("R9 second rdata", rsp_rdata, 32'h0102_0304);
    @(negedge clk); bus_rvalid = 0;
  endtask

  task automatic t_queue();
    bit m [4] = '{1, 0, 1, 0};
    set_cfg(32'h100);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      req_valid = 1; req_write = 0; req_size = 2;
      req_addr = 32'h400 + 32'(i * 4); req_page_attr = m[i];
    end
    @(negedge clk); req_valid = 0;
    for (int i = 0; i < 4; i++) begin
      bus_rvalid = 1; bus_rdata = 32'h1020_3040 + 32'(i);
      #1;
      check($sformatf("R9 queue entry %0d", i), rsp_rdata,
            exp_data(1, m[i], 32'h1020_3040 + 32'(i)));
      @(negedge clk);
    end
    bus_rvalid = 0;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sweep();
    t_cfg_bits();
    t_same_cycle();
    t_latched();
    t_queue();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule